// File: doc/BRIEF.md
# Credit-Based Round-Robin Transmit Scheduler

This block decides, cycle by cycle, which of N transmit ports may send its next burst over a multi-port packet link that uses per-port flow control. Every port reports how many bytes its FIFO holds and whether a packet end is sitting in that FIFO. A separate decoder delivers flow-control updates one at a time as a valid/port/code triple. The scheduler converts those updates into burst credits and serves the eligible ports in rotation. It produces a read enable, the port to read and the number of bytes in the burst.

Each port has two registers. The pending-credit register holds the grant carried by the most recent starving or hungry update. The live-credit counter holds the bursts the port may still send. When the live counter is empty, it takes the pending value and the pending register is cleared, so each update grants credit only once. A runtime bypass input makes the scheduler ignore flow control: any port with enough data is then served, whether or not it holds credit. The outputs are registered, so a decision appears one clock after the inputs that caused it. `rst_n` is asynchronous and active low, and it is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `tx_credit_sched`

## Requirements
- R1: While reset is active, and on the first edges after it, `rd_en` is low. Both credit tables start at zero and the rotation pointer starts at port 0, so the first grant after reset goes to port 0 when all ports are eligible.
- R2: A valid update with code 2'b00 (starving) writes MAX_BURST_STARVE into the addressed port's pending-credit register.
- R3: A valid update with code 2'b01 (hungry) writes MAX_BURST_HUNGRY into the addressed port's pending-credit register.
- R4: An update with code 2'b10 (satisfied), or with the reserved code 2'b11, leaves the pending-credit register as it was and grants no bursts.
- R5: A port has enough data only when its FIFO level is at least BURST_BYTES, or when its end-of-packet flag is set.
- R6: `rd_len` equals BURST_BYTES when the granted port's level is at least BURST_BYTES. Otherwise it equals that port's level.
- R7: On the edge after a port's live counter is zero and its pending register is nonzero, the live counter takes the pending value and the pending register becomes zero. A single update therefore yields exactly its credit amount of grants.
- R8: Each grant to a port whose live counter is nonzero reduces that counter by one. With the bypass low, a port whose live counter is zero is never granted.
- R9: The search starts at the rotation pointer and goes upward, wrapping around. The first requesting port wins. After a grant, the pointer moves to the port after the winner. The grant appears on `rd_en`/`rd_port`/`rd_len` one edge after the inputs that caused it.
- R10: With `ignore_bp` high, every port that has enough data requests, whatever its credit. A live counter that is already zero stays at zero when its port is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ignore_bp | input | 1 | Bypass flow control when high |
| st_valid | input | 1 | A flow-control update is present this cycle |
| st_port | input | PTR_W | Port addressed by the update |
| st_code | input | 2 | Update code: 00 starving, 01 hungry, 10 satisfied, 11 reserved |
| fifo_level | input | NPORTS*LVL_W | Per-port FIFO byte count, port p at bits p*LVL_W upward |
| fifo_eop | input | NPORTS | Per-port end-of-packet present flag |
| rd_en | output | 1 | Read one burst from the selected port |
| rd_port | output | PTR_W | Selected port |
| rd_len | output | LVL_W | Bytes in the granted burst |

## Verification
The bench watches the boundary of a FIFO level that is exactly one burst, one byte under it, and a short packet released only by its end flag. A design with an off-by-one compare would grant early or stall. A design that ignored the end flag would never send the short tail, and a wrong length choice would show up in `rd_len`. The bench also stacks repeated hungry and satisfied updates while a port still holds credit. A design that cleared pending credit on a satisfied update, or that reused a pending value twice, would then produce the wrong total number of grants. Finally, it resets with all ports loaded and the bypass high. A pointer that did not start at zero, or a counter that wrapped below zero in bypass mode, would produce the wrong grant order or extra grants.

// File: rtl/txs_pkg.sv
`timescale 1ns/1ps
package txs_pkg;
  typedef enum logic [1:0] {
    FC_STARVING  = 2'b00,
    FC_HUNGRY    = 2'b01,
    FC_SATISFIED = 2'b10,
    FC_RESERVED  = 2'b11
  } fc_code_e;
endpackage

// File: rtl/txs_port_credit.sv
`timescale 1ns/1ps
// Per-port pending-credit register and live-credit counter.
module txs_port_credit #(
  parameter int CRED_W = 8,
  parameter int MAXB1  = 8,
  parameter int MAXB2  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        upd_code,
  input  logic              take,
  output logic [CRED_W-1:0] pend_q,
  output logic [CRED_W-1:0] live_q,
  output logic              live_nz
);
  import txs_pkg::*;

  logic [CRED_W-1:0] pend_d, live_d;
  logic              refill, ce;

  assign live_nz = (live_q != '0);
  assign refill  = !live_nz && (pend_q != '0);

  always_comb begin
    pend_d = pend_q;
    live_d = live_q;
    if (take && live_nz) begin
      live_d = live_q - CRED_W'(1);
    end else if (refill) begin
      live_d = pend_q;
      pend_d = '0;
    end
    if (upd_en) begin
      case (fc_code_e'(upd_code))
        FC_STARVING: pend_d = CRED_W'(MAXB1);
        FC_HUNGRY:   pend_d = CRED_W'(MAXB2);
        default:     ;
      endcase
    end
  end

  assign ce = upd_en | (take & live_nz) | refill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      live_q <= '0;
    end else if (ce) begin
      pend_q <= pend_d;
      live_q <= live_d;
    end
  end
endmodule

// File: rtl/txs_elig.sv
`timescale 1ns/1ps
// Data sufficiency, request vector and per-port burst length.
module txs_elig #(
  parameter int NPORTS = 4,
  parameter int LVL_W  = 8,
  parameter int BURST  = 16
) (
  input  logic [NPORTS*LVL_W-1:0] fifo_level,
  input  logic [NPORTS-1:0]       fifo_eop,
  input  logic [NPORTS-1:0]       live_nz,
  input  logic                    ignore_bp,
  output logic [NPORTS-1:0]       data_ok,
  output logic [NPORTS-1:0]       req,
  output logic [NPORTS*LVL_W-1:0] len_flat
);
  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [LVL_W-1:0] lvl;
    logic             full_unit;
    assign lvl        = fifo_level[p*LVL_W +: LVL_W];
    assign full_unit  = (lvl >= BURST_L);
    assign data_ok[p] = full_unit | fifo_eop[p];
    assign req[p]     = data_ok[p] & (ignore_bp | live_nz[p]);
    assign len_flat[p*LVL_W +: LVL_W] = full_unit ? BURST_L : lvl;
  end
endmodule

// File: rtl/txs_rr_pick.sv
`timescale 1ns/1ps
// Rotating-priority picker: first requester at or above ptr, wrapping.
module txs_rr_pick #(
  parameter int NPORTS = 4,
  parameter int PTR_W  = 2
) (
  input  logic [NPORTS-1:0] req,
  input  logic [PTR_W-1:0]  ptr,
  output logic              hit,
  output logic [PTR_W-1:0]  win
);
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = 0; i < NPORTS; i++) begin
      int cand;
      cand = int'(ptr) + i;
      if (cand >= NPORTS) cand = cand - NPORTS;
      if (!hit && req[cand]) begin
        hit = 1'b1;
        win = PTR_W'(cand);
      end
    end
  end
endmodule

// File: rtl/tx_credit_sched.sv
`timescale 1ns/1ps
module tx_credit_sched #(
  parameter int NPORTS           = 4,
  parameter int LVL_W            = 8,
  parameter int BURST_BYTES      = 16,
  parameter int CRED_W           = 8,
  parameter int MAX_BURST_STARVE = 8,
  parameter int MAX_BURST_HUNGRY = 4,
  parameter int PTR_W            = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ignore_bp,
  input  logic                    st_valid,
  input  logic [PTR_W-1:0]        st_port,
  input  logic [1:0]              st_code,
  input  logic [NPORTS*LVL_W-1:0] fifo_level,
  input  logic [NPORTS-1:0]       fifo_eop,
  output logic                    rd_en,
  output logic [PTR_W-1:0]        rd_port,
  output logic [LVL_W-1:0]        rd_len
);
  localparam logic [PTR_W-1:0] LAST_PORT = PTR_W'(NPORTS - 1);

  logic [NPORTS*CRED_W-1:0] pend_flat, live_flat;
  logic [NPORTS-1:0]        live_nz, data_ok, req;
  logic [NPORTS*LVL_W-1:0]  len_flat;
  logic                     hit;
  logic [PTR_W-1:0]         win, ptr_q, ptr_d;
  logic                     rd_en_d;
  logic [PTR_W-1:0]         rd_port_d;
  logic [LVL_W-1:0]         rd_len_d;

  for (genvar p = 0; p < NPORTS; p++) begin : g_cred
    logic take_p, upd_p;
    assign take_p = hit && (win == PTR_W'(p));
    assign upd_p  = st_valid && (st_port == PTR_W'(p));
    txs_port_credit #(
      .CRED_W(CRED_W), .MAXB1(MAX_BURST_STARVE), .MAXB2(MAX_BURST_HUNGRY)
    ) u_cred (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (upd_p),
      .upd_code(st_code),
      .take    (take_p),
      .pend_q  (pend_flat[p*CRED_W +: CRED_W]),
      .live_q  (live_flat[p*CRED_W +: CRED_W]),
      .live_nz (live_nz[p])
    );
  end

  txs_elig #(.NPORTS(NPORTS), .LVL_W(LVL_W), .BURST(BURST_BYTES)) u_elig (
    .fifo_level(fifo_level),
    .fifo_eop  (fifo_eop),
    .live_nz   (live_nz),
    .ignore_bp (ignore_bp),
    .data_ok   (data_ok),
    .req       (req),
    .len_flat  (len_flat)
  );

  txs_rr_pick #(.NPORTS(NPORTS), .PTR_W(PTR_W)) u_pick (
    .req(req),
    .ptr(ptr_q),
    .hit(hit),
    .win(win)
  );

  // Next state for pointer and output stage
  always_comb begin
    ptr_d     = ptr_q;
    rd_en_d   = hit;
    rd_port_d = rd_port;
    rd_len_d  = rd_len;
    if (hit) begin
      ptr_d     = (win == LAST_PORT) ? '0 : win + PTR_W'(1);
      rd_port_d = win;
      rd_len_d  = len_flat[win*LVL_W +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rd_en   <= 1'b0;
      rd_port <= '0;
      rd_len  <= '0;
    end else begin
      rd_en <= rd_en_d;
      if (hit) begin
        ptr_q   <= ptr_d;
        rd_port <= rd_port_d;
        rd_len  <= rd_len_d;
      end
    end
  end
endmodule

// File: rtl/tx_credit_sched_chk.sv
`timescale 1ns/1ps
module tx_credit_sched_chk #(
  parameter int NPORTS = 4,
  parameter int LVL_W  = 8,
  parameter int BURST  = 16,
  parameter int CRED_W = 8,
  parameter int MAXB1  = 8,
  parameter int MAXB2  = 4,
  parameter int PTR_W  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ignore_bp,
  input logic                     st_valid,
  input logic [PTR_W-1:0]         st_port,
  input logic [1:0]               st_code,
  input logic [NPORTS*LVL_W-1:0]  fifo_level,
  input logic [NPORTS-1:0]        fifo_eop,
  input logic                     rd_en,
  input logic [PTR_W-1:0]         rd_port,
  input logic [NPORTS*CRED_W-1:0] pend_flat,
  input logic [NPORTS*CRED_W-1:0] live_flat
);
  logic [CRED_W-1:0] pend_a [NPORTS];
  logic [NPORTS-1:0] ok_now, live_nz_now;
  logic [NPORTS-1:0] ok_prev, live_nz_prev;
  logic              ign_prev, lv, lnz;
  logic [PTR_W-1:0]  lp;
  logic [1:0]        lc;
  logic [CRED_W-1:0] lpend;

  for (genvar p = 0; p < NPORTS; p++) begin : g_a
    assign pend_a[p]      = pend_flat[p*CRED_W +: CRED_W];
    assign live_nz_now[p] = (live_flat[p*CRED_W +: CRED_W] != '0);
    assign ok_now[p]      = (fifo_level[p*LVL_W +: LVL_W] >= LVL_W'(BURST)) | fifo_eop[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_prev <= '0; live_nz_prev <= '0; ign_prev <= 1'b0;
      lv <= 1'b0; lp <= '0; lc <= '0; lnz <= 1'b0; lpend <= '0;
    end else begin
      ok_prev <= ok_now; live_nz_prev <= live_nz_now; ign_prev <= ignore_bp;
      lv <= st_valid; lp <= st_port; lc <= st_code;
      lnz <= live_nz_now[st_port]; lpend <= pend_a[st_port];
    end
  end

  AST_GRANT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ok_prev[rd_port]);                                         // R5
  AST_BP_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ign_prev) |-> live_nz_prev[rd_port]);                     // R8
  AST_STARVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lv && lc == 2'b00) |-> pend_a[lp] == CRED_W'(MAXB1));               // R2
  AST_HUNGRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lv && lc == 2'b01) |-> pend_a[lp] == CRED_W'(MAXB2));               // R3
  AST_SATISFIED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lv && lc[1] && lnz) |-> pend_a[lp] == lpend);                       // R4
endmodule

bind tx_credit_sched tx_credit_sched_chk #(
  .NPORTS(NPORTS), .LVL_W(LVL_W), .BURST(BURST_BYTES), .CRED_W(CRED_W),
  .MAXB1(MAX_BURST_STARVE), .MAXB2(MAX_BURST_HUNGRY), .PTR_W(PTR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ignore_bp(ignore_bp), .st_valid(st_valid),
  .st_port(st_port), .st_code(st_code), .fifo_level(fifo_level),
  .fifo_eop(fifo_eop), .rd_en(rd_en), .rd_port(rd_port),
  .pend_flat(pend_flat), .live_flat(live_flat)
);

// File: tb/tx_credit_sched_tb_top.sv
`timescale 1ns/1ps
module tx_credit_sched_tb_top;
  localparam int N = 4, LW = 8, BB = 16, MB1 = 8, MB2 = 4, PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ignore_bp = 1'b0, st_valid = 1'b0;
  logic [PW-1:0] st_port = '0;
  logic [1:0] st_code = '0;
  logic [N*LW-1:0] fifo_level = '0;
  logic [N-1:0] fifo_eop = '0;
  logic rd_en;
  logic [PW-1:0] rd_port;
  logic [LW-1:0] rd_len;

  always #2.5 clk = ~clk;

  tx_credit_sched #(.NPORTS(N), .LVL_W(LW), .BURST_BYTES(BB), .CRED_W(8),
    .MAX_BURST_STARVE(MB1), .MAX_BURST_HUNGRY(MB2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ignore_bp(ignore_bp), .st_valid(st_valid),
    .st_port(st_port), .st_code(st_code), .fifo_level(fifo_level),
    .fifo_eop(fifo_eop), .rd_en(rd_en), .rd_port(rd_port), .rd_len(rd_len));

  typedef struct { bit en; int port; int len; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  int gcnt [N];
  int first_port = -1;
  string cur_req = "R1";
  bit finished = 0;
  int nc_m [N], cr_m [N], ptr_m;

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic clear_counts();
    for (int p = 0; p < N; p++) gcnt[p] = 0;
    first_port = -1;
  endtask

  // Monitor: pop expected item after each edge and compare
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(cur_req, "rd_en", int'(rd_en), int'(e.en));
        if (e.en && rd_en) begin
          check("R9", "rd_port", int'(rd_port), e.port);
          check("R6", "rd_len", int'(rd_len), e.len);
          gcnt[rd_port]++;
          if (first_port < 0) first_port = int'(rd_port);
        end
      end
    end
  end

  function automatic int lvl_of(int p);
    return int'(fifo_level[p*LW +: LW]);
  endfunction

  // Driver: apply current inputs, predict one edge, push, advance
  task automatic step();
    exp_t e;
    int g = -1;
    for (int i = 0; i < N; i++) begin
      int c = (ptr_m + i) % N;
      bit ok = (lvl_of(c) >= BB) || fifo_eop[c];
      if (g < 0 && ok && (ignore_bp || cr_m[c] > 0)) g = c;
    end
    e.en = (g >= 0); e.port = g;
    e.len = (g >= 0) ? ((lvl_of(g) >= BB) ? BB : lvl_of(g)) : 0;
    exp_q.push_back(e);
    for (int p = 0; p < N; p++) begin
      if (g == p && cr_m[p] > 0) cr_m[p]--;
      else if (cr_m[p] == 0 && nc_m[p] != 0) begin cr_m[p] = nc_m[p]; nc_m[p] = 0; end
      if (st_valid && int'(st_port) == p) begin
        if (st_code == 2'b00) nc_m[p] = MB1;
        else if (st_code == 2'b01) nc_m[p] = MB2;
      end
    end
    if (g >= 0) ptr_m = (g + 1) % N;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic status(int p, logic [1:0] code);
    st_valid = 1'b1; st_port = PW'(p); st_code = code;
    step();
  endtask

  task automatic set_lvl(int p, int v);
    fifo_level[p*LW +: LW] = LW'(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int p = 0; p < N; p++) begin nc_m[p] = 0; cr_m[p] = 0; end
    ptr_m = 0;
    repeat (2) @(negedge clk);
    check("R1", "rd_en in reset", int'(rd_en), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    cur_req = "R1"; clear_counts();
    run(3);
    check("R1", "grants with empty tables", gcnt[0] + gcnt[1] + gcnt[2] + gcnt[3], 0);

    // R2 / R7 / R8: starving grants exactly MAXB1 bursts once
    cur_req = "R2"; clear_counts();
    set_lvl(0, 20);
    status(0, 2'b00);
    run(15);
    check("R2", "port0 grants after starving", gcnt[0], MB1);
    check("R7", "no second use of pending credit", gcnt[0], 8);

    // R3: hungry grants MAXB2
    cur_req = "R3"; clear_counts();
    set_lvl(1, 20);
    status(1, 2'b01);
    run(10);
    check("R3", "port1 grants after hungry", gcnt[1], MB2);

    // R5: one byte below a burst unit, then exactly a burst unit
    cur_req = "R5"; clear_counts();
    set_lvl(1, 15);
    status(1, 2'b01);
    run(6);
    check("R5", "port1 level 15 no eop", gcnt[1], 0);
    set_lvl(1, 16);
    run(8);
    check("R5", "port1 level 16", gcnt[1], 4);

    // R5 / R6: short packet released by end-of-packet flag
    cur_req = "R6"; clear_counts();
    set_lvl(2, 5);
    status(2, 2'b00);
    run(6);
    check("R5", "port2 short without eop", gcnt[2], 0);
    fifo_eop[2] = 1'b1;
    run(12);
    check("R6", "port2 short with eop", gcnt[2], MB1);
    fifo_eop[2] = 1'b0; set_lvl(2, 0);

    // R4: satisfied and reserved keep pending credit
    cur_req = "R4"; clear_counts();
    set_lvl(3, 0);
    status(3, 2'b01);
    run(2);
    status(3, 2'b01);
    status(3, 2'b10);
    status(3, 2'b11);
    set_lvl(3, 20);
    run(14);
    check("R4", "port3 grants hungry+hungry+sat", gcnt[3], 2 * MB2);
    clear_counts();
    status(3, 2'b11);
    status(3, 2'b10);
    run(5);
    check("R4", "reserved/satisfied grant nothing", gcnt[3], 0);

    // R9: rotation among all ports
    cur_req = "R9"; clear_counts();
    for (int p = 0; p < N; p++) set_lvl(p, 20);
    for (int p = 0; p < N; p++) status(p, 2'b00);
    run(40);
    for (int p = 0; p < N; p++) check("R9", "rotation share", gcnt[p], MB1);

    // R1 / R10: after reset, bypass mode, no credits
    do_reset();
    cur_req = "R10"; clear_counts();
    ignore_bp = 1'b1;
    run(8);
    check("R1", "first grant after reset", first_port, 0);
    for (int p = 0; p < N; p++) check("R10", "bypass grants", gcnt[p], 2);
    ignore_bp = 1'b0;
    clear_counts();
    cur_req = "R8";
    run(4);
    check("R10", "credits stay zero after bypass", gcnt[0] + gcnt[1] + gcnt[2] + gcnt[3], 0);

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule